// File: doc/BRIEF.md
# Masked Multi-Pattern Packet Matcher

This block watches the opening bytes of a received packet and tests them against four programmable templates at the same time. Each template is a string of pattern bytes. Every pattern byte carries its own don't-care bit. Templates 0 and 1 hold up to 64 bytes each, and templates 2 and 3 hold up to 128 bytes each. Each template has its own compare length, and a template only scores a hit when every compared byte either equals the packet byte or is marked don't-care.

Templates and lengths are loaded through an indirect write port. The port carries a 10-bit address, 16 data bits and two mask bits. The packet arrives as one byte per clock, framed by start and end markers. The block reports one registered hit flag per template and an aggregate flag. Each hit flag is gated by a per-template enable. Frame storage and the accept/reject decision belong to the surrounding receive path.

Top module: `pm_matcher`

## Requirements
- R1: After reset, `pat_hit` is 0000 and `any_hit` is 0, and every compare length is 0.
- R2: Packet byte k is compared with template byte k. Even k uses bits 7:0 of template word k/2, and odd k uses bits 15:8. When all compared bytes match, `pat_hit[p]` rises in the clock cycle after the byte with index (length-1) is accepted, and not earlier.
- R3: A single unmasked byte that differs within the compare length leaves `pat_hit[p]` at 0 for that frame.
- R4: Word bit 16 makes the even byte of that word a don't-care, and word bit 17 does the same for the odd byte. A masked byte matches any value.
- R5: Packet bytes at or beyond a template's compare length do not affect that template's flag.
- R6: The compare length is a byte count. A value below 2 keeps the template from ever hitting. A value above the template size (64 for templates 0 and 1, 128 for templates 2 and 3) behaves as the template size.
- R7: If the frame ends (`rx_eof` on the last byte) before a template's length is reached, that template's flag stays 0.
- R8: A template whose `pat_en` bit is 0 during its final compared byte does not set its flag.
- R9: Word n of template 0 is written at 280h+4n and word n of template 1 at 282h+4n. Word n of template 2 is written at 300h+4n and word n of template 3 at 302h+4n. Address bit 0 is ignored. Address 006h holds the length of template 0 in data bits 7:0 and template 1 in bits 15:8. Address 008h holds template 2 in bits 7:0 and template 3 in bits 15:8.
- R10: `any_hit` is 1 exactly when at least one `pat_hit` bit is 1.
- R11: Flags are cleared by the first byte of the next frame and are otherwise held, including through idle cycles.
- R12: Bytes with `rx_valid` high that arrive outside a frame do not change any flag. Outside a frame means after an end marker and before the next start marker, or before the first start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 10 | Indirect configuration address |
| cfg_wdata | input | 18 | Bits 15:0 data; bits 17:16 byte don't-care bits |
| rx_valid | input | 1 | Packet byte present this cycle |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_byte | input | 8 | Packet byte |
| pat_en | input | 4 | Per-template enable |
| pat_hit | output | 4 | Per-template hit flag, registered |
| any_hit | output | 1 | OR of the hit flags |

## Verification
A template's hit flag is registered on the clock edge that accepts the final compared byte. The bench drives each byte on a falling edge and records the flags on the next falling edge. That record is taken half a cycle after the accepting edge, so the sample stored for byte k is the first place a result due at byte k can appear. The checks compare the sample at index length-1 for the expected hit and the sample at length-2 for its absence. Held-value checks after frames and idle gaps are taken at falling edges, after the last byte has been taken in.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int BYTE_W  = 8;
  localparam int DATA_W  = 16;
  localparam int MASK_W  = 2;
  localparam int CNT_W   = 8;
  localparam int ADDR_W  = 10;
  localparam int NUM_PAT = 4;

  localparam logic [ADDR_W-1:0] PAIR01_BASE = 10'h280;
  localparam logic [ADDR_W-1:0] PAIR23_BASE = 10'h300;
  localparam logic [ADDR_W-1:0] LEN01_ADDR  = 10'h006;
  localparam logic [ADDR_W-1:0] LEN23_ADDR  = 10'h008;

  // mask[0] frees the even byte (data[7:0]), mask[1] the odd byte
  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [DATA_W-1:0] data;
  } pat_word_t;
endpackage

// File: rtl/pm_stream_tracker.sv
module pm_stream_tracker
  import pm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic             rx_sof,
  input  logic             rx_eof,
  output logic             take,
  output logic             first,
  output logic [CNT_W-1:0] idx
);
  logic             in_frame;
  logic [CNT_W-1:0] next_idx;

  assign first = rx_valid & rx_sof;
  assign take  = rx_valid & (rx_sof | in_frame);
  assign idx   = rx_sof ? '0 : next_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame <= 1'b0;
      next_idx <= '0;
    end else if (take) begin
      in_frame <= ~rx_eof;
      next_idx <= (&idx) ? idx : idx + 1'b1;  // saturate on long frames
    end
  end
endmodule

// File: rtl/pm_lane.sv
module pm_lane
  import pm_pkg::*;
#(
  parameter int WORDS = 32,
  localparam int WA_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WA_W-1:0]  wr_addr,
  input  pat_word_t        wr_word,
  input  logic [CNT_W-1:0] length,
  input  logic             enable,
  input  logic             take,
  input  logic             first,
  input  logic [CNT_W-1:0] idx,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic             hit
);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(2 * WORDS);

  pat_word_t mem [WORDS];
  pat_word_t rd;
  logic [BYTE_W-1:0] want;
  logic              dont_care, byte_ok, run_ok, run_nxt, len_ok;
  logic [CNT_W-1:0]  eff_len, last_idx;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_word;
  end

  assign rd        = mem[idx[WA_W:1]];
  assign want      = idx[0] ? rd.data[DATA_W-1:BYTE_W] : rd.data[BYTE_W-1:0];
  assign dont_care = idx[0] ? rd.mask[1] : rd.mask[0];
  assign byte_ok   = dont_care | (want == rx_byte);

  assign eff_len  = (length > CAP) ? CAP : length;
  assign len_ok   = length >= CNT_W'(2);
  assign last_idx = eff_len - 1'b1;
  assign run_nxt  = (first | run_ok) & byte_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_ok <= 1'b0;
      hit    <= 1'b0;
    end else if (take) begin
      run_ok <= run_nxt;
      if (first)
        hit <= 1'b0;
      else if (len_ok && idx == last_idx)
        hit <= run_nxt & enable;
    end
  end
endmodule

// File: rtl/pm_matcher.sv
module pm_matcher
  import pm_pkg::*;
#(
  parameter int BUF01_WORDS = 32,
  parameter int BUF23_WORDS = 64
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [DATA_W+MASK_W-1:0]   cfg_wdata,
  input  logic                       rx_valid,
  input  logic                       rx_sof,
  input  logic                       rx_eof,
  input  logic [BYTE_W-1:0]          rx_byte,
  input  logic [NUM_PAT-1:0]         pat_en,
  output logic [NUM_PAT-1:0]         pat_hit,
  output logic                       any_hit
);
  logic [NUM_PAT-1:0][CNT_W-1:0] len_q;
  logic             take, first;
  logic [CNT_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == LEN01_ADDR) begin
        len_q[0] <= cfg_wdata[BYTE_W-1:0];
        len_q[1] <= cfg_wdata[DATA_W-1:BYTE_W];
      end else if (cfg_addr == LEN23_ADDR) begin
        len_q[2] <= cfg_wdata[BYTE_W-1:0];
        len_q[3] <= cfg_wdata[DATA_W-1:BYTE_W];
      end
    end
  end

  pm_stream_tracker u_trk (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_eof(rx_eof), .take(take), .first(first), .idx(idx)
  );

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_lane
    localparam int WORDS = (p < 2) ? BUF01_WORDS : BUF23_WORDS;
    localparam int WA_W  = $clog2(WORDS);
    localparam logic [ADDR_W-1:0] BASE = (p < 2) ? PAIR01_BASE : PAIR23_BASE;
    localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 * WORDS);
    localparam logic SIDE = (p % 2) == 1;

    logic [ADDR_W-1:0] offs;
    logic              sel;
    pat_word_t         wword;

    assign offs  = cfg_addr - BASE;
    assign sel   = cfg_we && (cfg_addr >= BASE) && (offs < SPAN) && (offs[1] == SIDE);
    assign wword = cfg_wdata;

    pm_lane #(.WORDS(WORDS)) u_lane (
      .clk(clk), .rst(rst), .wr_en(sel), .wr_addr(offs[WA_W+1:2]),
      .wr_word(wword), .length(len_q[p]), .enable(pat_en[p]),
      .take(take), .first(first), .idx(idx), .rx_byte(rx_byte),
      .hit(pat_hit[p])
    );
  end

  assign any_hit = |pat_hit;
endmodule

// File: rtl/pm_matcher_chk.sv
module pm_matcher_chk
  import pm_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               rx_valid,
  input logic               rx_sof,
  input logic               rx_eof,
  input logic [NUM_PAT-1:0] pat_en,
  input logic [NUM_PAT-1:0] pat_hit
);
  logic seen_open;

  always_ff @(posedge clk) begin
    if (rst) seen_open <= 1'b0;
    else if (rx_valid && (rx_sof || seen_open)) seen_open <= !rx_eof;
  end

  assert_clear_on_start_R11: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sof) |=> (pat_hit == '0));

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rx_valid |=> $stable(pat_hit));

  assert_stray_bytes_ignored_R12: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_sof && !seen_open) |=> $stable(pat_hit));

  assert_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
    ((pat_hit & ~$past(pat_hit) & ~$past(pat_en)) == '0));

  assert_rise_after_byte_R2: assert property (@(posedge clk) disable iff (rst)
    ((pat_hit & ~$past(pat_hit)) != '0) |-> $past(rx_valid && !rx_sof));
endmodule

bind pm_matcher pm_matcher_chk u_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
  .rx_eof(rx_eof), .pat_en(pat_en), .pat_hit(pat_hit)
);

// File: tb/pm_matcher_test.sv
module pm_matcher_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [9:0]  cfg_addr = '0;
  logic [17:0] cfg_wdata = '0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic [3:0]  pat_en = 4'hF;
  logic [3:0]  pat_hit;
  logic        any_hit;

  int n_total = 0, n_pass = 0;
  logic [7:0] frm    [256];
  logic [3:0] hit_at [256];
  logic       any_at [256];

  always #4 clk = ~clk;

  pm_matcher uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (act === exp) n_pass++;
    else $display("FAIL %s: actual %0h expected %0h", req, act, exp);
  endtask

  function automatic logic [7:0] pb(input int p, input int j);
    return 8'(p * 64) ^ 8'(j);
  endfunction

  task automatic cfg_write(input logic [9:0] a, input logic [17:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_all();
    for (int p = 0; p < 4; p++) begin
      int words = (p < 2) ? 32 : 64;
      int base  = (p < 2) ? 'h280 : 'h300;
      for (int n = 0; n < words; n++)
        cfg_write(10'(base + 4 * n + 2 * (p % 2)), {2'b00, pb(p, 2 * n + 1), pb(p, 2 * n)});
    end
  endtask

  task automatic fill(input int p);
    int bytes = (p < 2) ? 64 : 128;
    for (int i = 0; i < 256; i++) frm[i] = (i < bytes) ? pb(p, i) : 8'hEE;
  endtask

  task automatic send(input int len, input bit with_sof, input bit with_eof);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_sof = with_sof && (i == 0);
      rx_eof = with_eof && (i == len - 1); rx_byte = frm[i];
      @(negedge clk);
      hit_at[i] = pat_hit; any_at[i] = any_hit;
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 hit flags after reset", 32'(pat_hit), 32'h0);
    chk("R1 any_hit after reset", 32'(any_hit), 32'h0);
    fill(0); send(16, 1, 1);  // lengths still zero
    chk("R1 zero lengths give no hit", 32'(hit_at[15]), 32'h0);
  endtask

  task automatic t_basic();
    cfg_write(10'h006, 18'h00406);
    cfg_write(10'h008, 18'h00406);
    fill(0); send(16, 1, 1);
    chk("R2 no hit before last compared byte", 32'(hit_at[4]), 32'h0);
    chk("R2 hit one cycle after byte 5", 32'(hit_at[5]), 32'h1);
    chk("R10 any_hit with a hit", 32'(any_at[5]), 32'h1);
    chk("R5 later bytes ignored", 32'(hit_at[15]), 32'h1);
    fill(1); send(10, 1, 1);
    chk("R9 template 1 at 282h+4n", 32'(hit_at[3]), 32'h2);
    fill(2); send(10, 1, 1);
    chk("R9 template 2 at 300h+4n", 32'(hit_at[5]), 32'h4);
    fill(3); send(10, 1, 1);
    chk("R9 template 3 at 302h+4n", 32'(hit_at[3]), 32'h8);
  endtask

  task automatic t_mismatch();
    fill(0); frm[3] = frm[3] ^ 8'h01; send(8, 1, 1);
    chk("R3 one wrong byte", 32'(hit_at[7]), 32'h0);
    chk("R10 any_hit low without hit", 32'(any_at[7]), 32'h0);
    fill(0); frm[0] = pb(0, 1); frm[1] = pb(0, 0); send(8, 1, 1);
    chk("R2 even byte compared first", 32'(hit_at[7]), 32'h0);
  endtask

  task automatic t_clear_hold();
    fill(0); send(8, 1, 1);
    repeat (3) @(negedge clk);
    chk("R11 flag held through idle", 32'(pat_hit), 32'h1);
    fill(0); frm[0] = 8'h77; send(2, 1, 1);
    chk("R11 cleared by next start", 32'(hit_at[0]), 32'h0);
  endtask

  task automatic t_mask();
    cfg_write(10'h284, {2'b01, pb(0, 3), pb(0, 2)});
    cfg_write(10'h288, {2'b10, pb(0, 5), pb(0, 4)});
    fill(0); frm[2] = 8'h5A; frm[5] = 8'hA5; send(8, 1, 1);
    chk("R4 masked bytes are don't-care", 32'(hit_at[5]), 32'h1);
    fill(0); frm[4] = 8'hA5; send(8, 1, 1);
    chk("R4 unmasked partner still compared", 32'(hit_at[5]), 32'h0);
  endtask

  task automatic t_short_and_stray();
    fill(1); send(3, 1, 1);
    repeat (2) @(negedge clk);
    chk("R7 early end leaves flag low", 32'(pat_hit), 32'h0);
    fill(1); send(6, 0, 0);
    chk("R12 bytes outside a frame ignored", 32'(hit_at[5]), 32'h0);
  endtask

  task automatic t_enable();
    pat_en = 4'b1011;
    fill(2); send(8, 1, 1);
    chk("R8 disabled template no hit", 32'(hit_at[5]), 32'h0);
    pat_en = 4'hF;
    fill(2); send(8, 1, 1);
    chk("R8 re-enabled template hits", 32'(hit_at[5]), 32'h4);
  endtask

  task automatic t_lengths();
    cfg_write(10'h006, 18'h00201);
    fill(0); send(8, 1, 1);
    chk("R6 length 1 never hits", 32'(hit_at[7]), 32'h0);
    fill(1); send(4, 1, 1);
    chk("R6 length 2 hits after byte 1", 32'(hit_at[1]), 32'h2);
    cfg_write(10'h008, {2'b00, 8'd200, 8'd6});
    fill(3); send(130, 1, 1);
    chk("R6 clamped length not early", 32'(hit_at[126]), 32'h0);
    chk("R6 clamped to 128 bytes", 32'(hit_at[127]), 32'h8);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    load_all();
    t_basic();
    t_mismatch();
    t_clear_hold();
    t_mask();
    t_short_and_stray();
    t_enable();
    t_lengths();
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  end
endmodule